// File: doc/BRIEF.md
# Perturbation Search Tap Adaptation Controller

This block tunes the coefficients of a four-tap feed-forward equalizer by trial and error. It never looks inside the filter. Once per tuning period an external detector hands it one scalar error value, marked by a valid strobe. From that value alone the block decides which coefficient to nudge next, and in which direction. The search runs until the error drops under a programmed tolerance, or until an iteration budget runs out.

The coefficient set is tied to the shape `[a, b, 0, -a]`, so only two magnitudes are ever searched. Each step moves one free tap by one unit. The search cycles through four moves: raise `a`, lower `a`, raise `b`, lower `b`. The block keeps repeating the current move while the error does not get worse. When the error gets worse, it goes on to the next move in that cycle. A start pulse loads the initial taps and the tolerance, and restarts the search. The done flag reports convergence, and a separate flag reports that the budget was exhausted.

Top module: `tap_adapt`

## Requirements
- R1: After reset, all four coefficient outputs are 0000, and `done` and `timedOut` are 0.
- R2: One cycle after a start pulse, `coef0` equals `initTapA` and `coef1` equals `initTapB`, and `done` and `timedOut` are 0. Coefficients are sign-magnitude: bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. An initial value of 1000 is loaded as 0000.
- R3: `coef2` is always 0000. `coef3` always has the magnitude of `coef0` with the opposite sign, and it is 0000 whenever `coef0` is zero.
- R4: An accepted error sample strictly below the tolerance sets `done` in the next cycle and leaves the coefficients unchanged. A sample equal to the tolerance does not count as converged.
- R5: The first accepted sample after a start only records the previous error. It changes no coefficient.
- R6: A later sample that is not larger than the previous one repeats the current move. After a start, the current move is "raise tap a".
- R7: A sample larger than the previous one advances the move in the order raise a, lower a, raise b, lower b, and then back to raise a. The new move is applied in the same cycle.
- R8: A raise saturates at +7 and a lower saturates at -7. A step through zero yields 0000 and then the opposite sign. A coefficient never holds negative zero.
- R9: While `done` is high, error samples change neither the outputs nor the search state, until the next start pulse.
- R10: The MAX_ITER-th accepted sample that is not below the tolerance sets both `done` and `timedOut`, and makes no coefficient change.
- R11: A start pulse during a search restarts it. The move returns to "raise tap a", the iteration count is cleared, and the next sample is treated as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Loads initial taps and tolerance, and starts a search |
| initTapA | input | MAG_W+1 | Initial first free tap (sign-magnitude) |
| initTapB | input | MAG_W+1 | Initial second free tap (sign-magnitude) |
| tolerance | input | ERR_W | Convergence threshold, captured on start |
| errValid | input | 1 | Error sample strobe, one per tuning period |
| errValue | input | ERR_W | Unsigned error magnitude |
| coef0 | output | MAG_W+1 | Tap 0 coefficient (= a) |
| coef1 | output | MAG_W+1 | Tap 1 coefficient (= b) |
| coef2 | output | MAG_W+1 | Tap 2 coefficient (always zero) |
| coef3 | output | MAG_W+1 | Tap 3 coefficient (= -a) |
| done | output | 1 | Search finished |
| timedOut | output | 1 | Search ended by the iteration budget |

## Verification
The hardest situation to reach from the ports is a tap held at its saturation bound, or crossing zero, while a particular move is active. The move only changes when the error rises, so the stimulus has to place that rise deliberately. Directed sequences do this. They feed a long run of equal errors to drive tap a up to +7 and hold it there. They then start from +1 and use a single rising error to switch to "lower a", so that equal errors carry the tap through 0000 down to -7. Random rounds add arbitrary initial values, including negative zero, and error sequences that are checked against a bench model. A reduced iteration budget makes the timeout reachable in a few dozen cycles.

// File: rtl/tap_adapt_pkg.sv
package tap_adapt_pkg;

  // Search moves in rotation order; bit 1 selects tap b, bit 0 selects a decrement.
  typedef enum logic [1:0] {
    MV_INC_A = 2'd0,
    MV_DEC_A = 2'd1,
    MV_INC_B = 2'd2,
    MV_DEC_B = 2'd3
  } searchMove_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture initial taps
    logic step;   // apply one unit move
    logic onB;    // move acts on tap b
    logic up;     // move is an increment
  } tapCmd_t;

endpackage

// File: rtl/tap_adapt_ctrl.sv
module tap_adapt_ctrl
  import tap_adapt_pkg::*;
#(
  parameter int ERR_W    = 12,
  parameter int MAX_ITER = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [ERR_W-1:0] tolerance,
  input  logic             errValid,
  input  logic [ERR_W-1:0] errValue,
  output tapCmd_t          cmd,
  output logic             done,
  output logic             timedOut
);

  localparam int ITER_W = $clog2(MAX_ITER + 1);

  logic             active;
  logic             firstSample;
  searchMove_t      move;
  searchMove_t      nextMove;
  logic [ERR_W-1:0] prevErr;
  logic [ERR_W-1:0] tolReg;
  logic [ITER_W-1:0] iterCnt;

  logic take;
  logic belowTol;
  logic lastIter;
  logic worse;

  always_comb begin
    take     = active && errValid && !startPulse;
    belowTol = errValue < tolReg;
    lastIter = iterCnt == ITER_W'(MAX_ITER - 1);
    worse    = errValue > prevErr;
    nextMove = worse ? searchMove_t'(move + 2'd1) : move;
    cmd.load = startPulse;
    cmd.step = take && !belowTol && !lastIter && !firstSample;
    cmd.onB  = nextMove[1];
    cmd.up   = !nextMove[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      firstSample <= 1'b1;
      move        <= MV_INC_A;
      prevErr     <= '0;
      tolReg      <= '0;
      iterCnt     <= '0;
      done        <= 1'b0;
      timedOut    <= 1'b0;
    end else if (startPulse) begin
      active      <= 1'b1;
      firstSample <= 1'b1;
      move        <= MV_INC_A;
      tolReg      <= tolerance;
      iterCnt     <= '0;
      done        <= 1'b0;
      timedOut    <= 1'b0;
    end else if (take) begin
      if (belowTol) begin
        done   <= 1'b1;
        active <= 1'b0;
      end else if (lastIter) begin
        done     <= 1'b1;
        timedOut <= 1'b1;
        active   <= 1'b0;
      end else begin
        prevErr     <= errValue;
        firstSample <= 1'b0;
        iterCnt     <= iterCnt + 1'b1;
        if (!firstSample) move <= nextMove;
      end
    end
  end

  AST_TIMEOUT_IS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> done); // R10

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt < ITER_W'(MAX_ITER)); // R10

  AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    done && !startPulse |=> done && $stable(move) && $stable(iterCnt) && $stable(prevErr)); // R9

  AST_MOVE_ROTATES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && errValue > prevErr |=> move == searchMove_t'($past(move) + 2'd1)); // R7

  AST_START_RESETS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> move == MV_INC_A && !done && iterCnt == '0); // R11

endmodule

// File: rtl/tap_adapt_dp.sv
module tap_adapt_dp
  import tap_adapt_pkg::*;
#(
  parameter int MAG_W = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  tapCmd_t        cmd,
  input  logic [MAG_W:0] initTapA,
  input  logic [MAG_W:0] initTapB,
  output logic [MAG_W:0] coef0,
  output logic [MAG_W:0] coef1,
  output logic [MAG_W:0] coef2,
  output logic [MAG_W:0] coef3
);

  localparam int COEF_W  = MAG_W + 1;
  localparam int SW      = MAG_W + 3;
  localparam int MAX_MAG = (1 << MAG_W) - 1;

  logic [COEF_W-1:0] tapA;
  logic [COEF_W-1:0] tapB;
  logic signed [SW-1:0] aVal;
  logic signed [SW-1:0] bVal;

  function automatic logic signed [SW-1:0] smToInt(input logic [COEF_W-1:0] sm);
    logic signed [SW-1:0] m;
    m = SW'(sm[MAG_W-1:0]);
    return sm[MAG_W] ? -m : m;
  endfunction

  function automatic logic [COEF_W-1:0] intToSm(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] a;
    a = (v < 0) ? -v : v;
    return {v < 0, a[MAG_W-1:0]};
  endfunction

  function automatic logic [COEF_W-1:0] cleanSm(input logic [COEF_W-1:0] sm);
    return (sm[MAG_W-1:0] == '0) ? '0 : sm;
  endfunction

  function automatic logic [COEF_W-1:0] stepSm(input logic [COEF_W-1:0] sm, input logic up);
    logic signed [SW-1:0] v;
    v = up ? smToInt(sm) + SW'(1) : smToInt(sm) - SW'(1);
    if (v > MAX_MAG)  v = SW'(MAX_MAG);
    if (v < -MAX_MAG) v = -SW'(MAX_MAG);
    return intToSm(v);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapA <= '0;
      tapB <= '0;
    end else if (cmd.load) begin
      tapA <= cleanSm(initTapA);
      tapB <= cleanSm(initTapB);
    end else if (cmd.step) begin
      if (cmd.onB) tapB <= stepSm(tapB, cmd.up);
      else         tapA <= stepSm(tapA, cmd.up);
    end
  end

  always_comb begin
    aVal  = smToInt(tapA);
    bVal  = smToInt(tapB);
    coef0 = tapA;
    coef1 = tapB;
    coef2 = '0;
    coef3 = cleanSm({~tapA[MAG_W], tapA[MAG_W-1:0]}); // R3 mirror of tap a
  end

  AST_NO_NEG_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    tapA[MAG_W-1:0] == '0 |-> !tapA[MAG_W]); // R8

  AST_NO_NEG_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    tapB[MAG_W-1:0] == '0 |-> !tapB[MAG_W]); // R8

  AST_RAISE_A_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !cmd.onB && cmd.up && !cmd.load |=>
      (aVal == $past(aVal) + SW'(1)) || (aVal == SW'(MAX_MAG) && $past(aVal) == SW'(MAX_MAG))); // R8

  AST_LOWER_B_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && cmd.onB && !cmd.up && !cmd.load |=>
      (bVal == $past(bVal) - SW'(1)) || (bVal == -SW'(MAX_MAG) && $past(bVal) == -SW'(MAX_MAG))); // R8

endmodule

// File: rtl/tap_adapt.sv
module tap_adapt
  import tap_adapt_pkg::*;
#(
  parameter int ERR_W    = 12,
  parameter int MAG_W    = 3,
  parameter int MAX_ITER = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [MAG_W:0]   initTapA,
  input  logic [MAG_W:0]   initTapB,
  input  logic [ERR_W-1:0] tolerance,
  input  logic             errValid,
  input  logic [ERR_W-1:0] errValue,
  output logic [MAG_W:0]   coef0,
  output logic [MAG_W:0]   coef1,
  output logic [MAG_W:0]   coef2,
  output logic [MAG_W:0]   coef3,
  output logic             done,
  output logic             timedOut
);

  tapCmd_t cmd;

  tap_adapt_ctrl #(.ERR_W(ERR_W), .MAX_ITER(MAX_ITER)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .tolerance  (tolerance),
    .errValid   (errValid),
    .errValue   (errValue),
    .cmd        (cmd),
    .done       (done),
    .timedOut   (timedOut)
  );

  tap_adapt_dp #(.MAG_W(MAG_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .initTapA (initTapA),
    .initTapB (initTapB),
    .coef0    (coef0),
    .coef1    (coef1),
    .coef2    (coef2),
    .coef3    (coef3)
  );

  AST_OUTPUT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    coef3[2:0] == coef0[2:0] && (coef0[2:0] == '0 || coef3[3] != coef0[3]) && coef2 == '0); // R3

endmodule

// File: tb/test_tap_adapt.sv
module test_tap_adapt;

  localparam int CLK_PERIOD = 10;
  localparam int TB_ITER    = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [3:0]  initTapA = '0;
  logic [3:0]  initTapB = '0;
  logic [11:0] tolerance = '0;
  logic        errValid = 1'b0;
  logic [11:0] errValue = '0;
  logic [3:0]  coef0, coef1, coef2, coef3;
  logic        done, timedOut;

  int nChecks = 0;
  int nFails  = 0;

  // bench model
  int mA, mB, mMove, mPrev, mIter, mTol;
  bit mFirst, mActive, mDone, mTo;

  tap_adapt #(.ERR_W(12), .MAG_W(3), .MAX_ITER(TB_ITER)) i_tap_adapt (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .initTapA(initTapA), .initTapB(initTapB), .tolerance(tolerance),
    .errValid(errValid), .errValue(errValue),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .done(done), .timedOut(timedOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] enc(input int v);
    return (v < 0) ? {1'b1, 3'(-v)} : {1'b0, 3'(v)};
  endfunction

  function automatic int decSm(input logic [3:0] sm);
    return sm[3] ? -int'(sm[2:0]) : int'(sm[2:0]);
  endfunction

  function automatic int clampStep(input int v, input bit up);
    int r;
    r = up ? v + 1 : v - 1;
    if (r > 7) r = 7;
    if (r < -7) r = -7;
    return r;
  endfunction

  task automatic check(input string tag);
    logic [17:0] act, exp;
    act = {coef0, coef1, coef2, coef3, done, timedOut};
    exp = {enc(mA), enc(mB), 4'b0000, enc(-mA), mDone, mTo};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic doStart(input logic [3:0] a, input logic [3:0] b, input int tol);
    @(negedge clk);
    startPulse = 1'b1; initTapA = a; initTapB = b; tolerance = 12'(tol);
    @(negedge clk);
    startPulse = 1'b0;
    mA = decSm(a); mB = decSm(b); mTol = tol; mMove = 0; mIter = 0;
    mFirst = 1; mActive = 1; mDone = 0; mTo = 0;
  endtask

  task automatic sample(input int e, output string tag);
    @(negedge clk);
    errValid = 1'b1; errValue = 12'(e);
    @(negedge clk);
    errValid = 1'b0;
    if (!mActive) tag = "R9";
    else if (e < mTol) begin mDone = 1; mActive = 0; tag = "R4"; end
    else if (mIter == TB_ITER - 1) begin mDone = 1; mTo = 1; mActive = 0; tag = "R10"; end
    else if (mFirst) begin mFirst = 0; mPrev = e; mIter++; tag = "R5"; end
    else begin
      if (e > mPrev) begin mMove = (mMove + 1) % 4; tag = "R7"; end
      else tag = "R6";
      if (mMove < 2) mA = clampStep(mA, mMove == 0);
      else           mB = clampStep(mB, mMove == 2);
      mPrev = e; mIter++;
    end
  endtask

  task automatic sampleCheck(input int e);
    string tag;
    sample(e, tag);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++; nChecks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    string tg;
    void'($urandom(32'd4711));
    mA = 0; mB = 0; mDone = 0; mTo = 0; mActive = 0; mFirst = 1;
    mMove = 0; mPrev = 0; mIter = 0; mTol = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // negative zero load, saturation upward on tap a
    doStart(4'b1000, 4'b0011, 5);
    check("R2");
    check("R3");
    sampleCheck(100);                      // R5 first sample only records
    for (int i = 0; i < 9; i++) sampleCheck(100); // R6 repeated raise a
    check("R8");                           // tap a held at +7
    sampleCheck(200);                      // R7 -> lower a
    sampleCheck(300);                      // R7 -> raise b
    sampleCheck(400);                      // R7 -> lower b
    sampleCheck(500);                      // R7 -> raise a
    sampleCheck(500);                      // R6
    sampleCheck(5);                        // R4 equal to tolerance: not converged
    sampleCheck(4);                        // R4 converged
    sampleCheck(600);                      // R9 ignored
    sampleCheck(0);                        // R9 ignored

    // zero crossing downward and saturation at -7
    doStart(4'b0001, 4'b0000, 1);
    sampleCheck(50);
    sampleCheck(60);                       // R7 lower a: 1 -> 0
    check("R8");
    sampleCheck(60);                       // R8 0 -> -1
    for (int i = 0; i < 8; i++) sampleCheck(60);
    check("R8");

    // restart during a search
    doStart(4'b0010, 4'b1010, 0);
    sampleCheck(10);
    sampleCheck(20);
    doStart(4'b0100, 4'b0001, 0);
    check("R11");
    sampleCheck(30);                       // first after restart: no change
    check("R11");
    sampleCheck(30);                       // raise a again
    check("R11");

    // timeout: tolerance 0 never met
    doStart(4'b0000, 4'b0000, 0);
    for (int i = 0; i < TB_ITER; i++) sampleCheck(1000 + (i % 3) * 7);
    check("R10");
    sampleCheck(0);                        // R9 ignored after timeout

    // random rounds
    for (int r = 0; r < 12; r++) begin
      doStart(4'($urandom), 4'($urandom), int'($urandom % 200));
      check("R2");
      for (int k = 0; k < 30; k++) begin
        sample(int'($urandom % 1200), tg);
        check(tg);
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule